// File: doc/BRIEF.md
# Cell Transmitter with CRC-10 Trailer Insertion

This block streams fixed-size cells out of a byte-wide buffer memory. Each cell lives in a 64-byte holder whose holder index is given with a transmit request. A request also carries one flag. With the flag set, the block computes a CRC-10 over the 48-byte payload unit and writes it into the last two trailer bytes. With the flag clear, the stored trailer bytes go out unchanged. Requests are queued in a small FIFO, and cells leave in the order they were requested.

A cell occupies holder bytes 12 to 63. Bytes 12 to 15 hold the 4-byte header. Bytes 16 to 63 hold the 48-byte payload unit, whose last two bytes are the trailer. The transmitter reads one byte per clock through a synchronous read port with one cycle of latency. The memory must hold its read data until the next read enable. The block presents each byte on a valid/ready byte stream and marks the first byte of each cell with a start flag. The block holds `tx_valid`, `tx_data` and `tx_sop` while `tx_ready` is low. A byte is consumed only on a cycle with both valid and ready high. No new memory read is issued during a stall, so no byte is lost or repeated.

The length field is stored right-justified in holder byte 62, in bits [5:0]. When the CRC is inserted, the block moves the length field into bits [7:2] of the outgoing byte. The two top CRC bits go in below it, and the low eight CRC bits make up the final byte.

Top module: `cell_tx_aal34`

## Requirements
- R1: A cell is sent as holder bytes 12 through 63 in ascending order, which is 52 bytes. `tx_sop` is high exactly on the first of them (holder byte 12).
- R2: For a request with the CRC flag at 0, holder bytes 62 and 63 are sent exactly as stored.
- R3: For a request with the CRC flag at 1, the byte sent for holder byte 62 is {stored bits [5:0], crc[9:8]} and the byte sent for holder byte 63 is crc[7:0]. Stored bits [7:6] of byte 62 and the stored byte 63 have no effect on the output.
- R4: The CRC uses the polynomial x^10+x^9+x^5+x^4+x+1. It is preset to zero for each cell and shifted MSB-first over holder bytes 16 to 61 and then over the six length bits. This result is the remainder that makes the whole 48-byte payload unit, as sent, divide with a zero remainder.
- R5: Header bytes 12 to 15 and payload bytes 16 to 61 are sent as stored, without zeroing. The header bytes are excluded from the CRC, and the payload bytes are included in it.
- R6: Cells are sent in the order their requests were accepted, and no byte is sent that was not requested.
- R7: While `tx_valid` is high and `tx_ready` is low, the next cycle still has `tx_valid` high with the same `tx_data` and `tx_sop`. No memory read is issued during that cycle.
- R8: A push arriving while FIFO_DEPTH requests are waiting is dropped. `req_overflow` is then high for exactly the one following cycle. An accepted push never raises it.
- R9: With requests waiting and `tx_ready` held high, consecutive cells are sent with no idle cycle, so N cells take 52*N consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_push | input | 1 | Enqueue a transmit request this cycle |
| req_holder | input | HOLDER_AW | Holder index of the cell (byte address = index*64) |
| req_crc_en | input | 1 | 1: generate and insert CRC-10; 0: send stored trailer |
| req_overflow | output | 1 | One-cycle pulse: the previous push was dropped because the FIFO was full |
| mem_rd_en | output | 1 | Read enable to the buffer memory |
| mem_rd_addr | output | HOLDER_AW+6 | Byte address to read |
| mem_rd_data | input | 8 | Read data, valid the cycle after `mem_rd_en` and held until the next read |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_data | output | 8 | Output byte |
| tx_sop | output | 1 | Current byte is the first byte of a cell |

## Verification
A wrong byte offset or a sequencer that slips shows up at once. The first misplaced byte breaks the compare against the bench's per-byte queue. It also shifts `tx_sop` away from its 52-byte spacing. A CRC register that is not cleared, or that is fed a header byte, goes unseen until the cell's trailer. The bench sees it in holder bytes 62 and 63, and in the receiver-side remainder over the 48 sent bytes, which must come out as zero. A stall that issues a read or changes the data fails on the very next clock. A FIFO with a bad count shows either as an overflow pulse in the wrong cycle or as a missing or extra cell at the end of a drain.

// File: rtl/cell_tx_pkg.sv
package cell_tx_pkg;
  localparam logic [9:0] CRC10_POLY = 10'h233;
  localparam logic [5:0] OFF_FIRST  = 6'd12;
  localparam logic [5:0] OFF_PDU    = 6'd16;
  localparam logic [5:0] OFF_LEN    = 6'd62;
  localparam logic [5:0] OFF_LAST   = 6'd63;
  localparam logic [5:0] OFF_PAY_END = 6'd61;

  function automatic logic [9:0] crc10_bit(input logic [9:0] c, input logic b);
    logic fb;
    fb = c[9] ^ b;
    return {c[8:0], 1'b0} ^ (fb ? CRC10_POLY : 10'h000);
  endfunction

  function automatic logic [9:0] crc10_byte(input logic [9:0] c, input logic [7:0] d);
    logic [9:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) r = crc10_bit(r, d[i]);
    return r;
  endfunction

  function automatic logic [9:0] crc10_len(input logic [9:0] c, input logic [5:0] l);
    logic [9:0] r;
    r = c;
    for (int i = 5; i >= 0; i--) r = crc10_bit(r, l[i]);
    return r;
  endfunction
endpackage

// File: rtl/tx_req_fifo.sv
module tx_req_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = slots[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slots[wp] <= wdata;
  end
endmodule

// File: rtl/crc10_unit.sv
module crc10_unit
  import cell_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       upd,
  input  logic [7:0] din,
  input  logic       fin_load,
  input  logic [5:0] len,
  output logic [9:0] crc_q,
  output logic [9:0] crc_fin
);
  assign crc_fin = crc10_len(crc_q, len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        crc_q <= '0;
    else if (clear)    crc_q <= '0;
    else if (fin_load) crc_q <= crc_fin;
    else if (upd)      crc_q <= crc10_byte(crc_q, din);
  end
endmodule

// File: rtl/trailer_merge.sv
module trailer_merge
  import cell_tx_pkg::*;
(
  input  logic       crc_on,
  input  logic [5:0] off,
  input  logic [7:0] raw,
  input  logic [9:0] crc_fin,
  input  logic [9:0] crc_q,
  output logic [7:0] dout
);
  always_comb begin
    dout = raw;
    if (crc_on) begin
      if (off == OFF_LEN)       dout = {raw[5:0], crc_fin[9:8]};
      else if (off == OFF_LAST) dout = crc_q[7:0];
    end
  end
endmodule

// File: rtl/cell_tx_aal34.sv
module cell_tx_aal34
  import cell_tx_pkg::*;
#(
  parameter int HOLDER_AW  = 6,
  parameter int FIFO_DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_push,
  input  logic [HOLDER_AW-1:0] req_holder,
  input  logic                 req_crc_en,
  output logic                 req_overflow,
  output logic                 mem_rd_en,
  output logic [HOLDER_AW+5:0] mem_rd_addr,
  input  logic [7:0]           mem_rd_data,
  output logic                 tx_valid,
  input  logic                 tx_ready,
  output logic [7:0]           tx_data,
  output logic                 tx_sop
);
  localparam int REQ_W = HOLDER_AW + 1;

  logic [REQ_W-1:0]     head;
  logic                 q_empty, q_full;
  logic                 launch, accept, last_acc;
  logic                 rd_valid_q;
  logic [5:0]           off_q;
  logic [HOLDER_AW-1:0] cur_holder_q;
  logic                 cur_crc_q;
  logic                 ovf_q;
  logic [9:0]           crc_q, crc_fin;
  logic                 crc_upd, crc_fin_load;

  tx_req_fifo #(.DEPTH(FIFO_DEPTH), .W(REQ_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (req_push),
    .wdata ({req_holder, req_crc_en}),
    .pop   (launch),
    .rdata (head),
    .empty (q_empty),
    .full  (q_full)
  );

  assign accept   = rd_valid_q && tx_ready;
  assign last_acc = accept && (off_q == OFF_LAST);
  assign launch   = (!rd_valid_q || last_acc) && !q_empty;

  assign mem_rd_en   = launch || (accept && !last_acc);
  assign mem_rd_addr = launch ? {head[REQ_W-1:1], OFF_FIRST}
                              : {cur_holder_q, off_q + 6'd1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q   <= 1'b0;
      off_q        <= '0;
      cur_holder_q <= '0;
      cur_crc_q    <= 1'b0;
      ovf_q        <= 1'b0;
    end else begin
      ovf_q <= req_push && q_full;
      if (launch) begin
        rd_valid_q   <= 1'b1;
        off_q        <= OFF_FIRST;
        cur_holder_q <= head[REQ_W-1:1];
        cur_crc_q    <= head[0];
      end else if (accept) begin
        off_q <= off_q + 6'd1;
        if (last_acc) rd_valid_q <= 1'b0;
      end
    end
  end

  assign crc_upd      = accept && (off_q >= OFF_PDU) && (off_q <= OFF_PAY_END);
  assign crc_fin_load = accept && (off_q == OFF_LEN);

  crc10_unit u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (launch),
    .upd      (crc_upd),
    .din      (mem_rd_data),
    .fin_load (crc_fin_load),
    .len      (mem_rd_data[5:0]),
    .crc_q    (crc_q),
    .crc_fin  (crc_fin)
  );

  trailer_merge u_merge (
    .crc_on  (cur_crc_q),
    .off     (off_q),
    .raw     (mem_rd_data),
    .crc_fin (crc_fin),
    .crc_q   (crc_q),
    .dout    (tx_data)
  );

  assign tx_valid     = rd_valid_q;
  assign tx_sop       = rd_valid_q && (off_q == OFF_FIRST);
  assign req_overflow = ovf_q;
endmodule

// File: rtl/cell_tx_aal34_chk.sv
module cell_tx_aal34_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_push,
  input logic       req_overflow,
  input logic       mem_rd_en,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       tx_sop
);
  logic [6:0] nbytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nbytes <= '0;
    else if (tx_valid && tx_ready) nbytes <= tx_sop ? 7'd1 : nbytes + 7'd1;
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sop));

  // R7
  stall_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |-> !mem_rd_en);

  // R1
  read_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> tx_valid);

  // R1
  sop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sop |-> tx_valid);

  // R1
  cell_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_sop |-> (nbytes == 7'd0 || nbytes == 7'd52));

  // R8
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_overflow |-> $past(req_push));
endmodule

bind cell_tx_aal34 cell_tx_aal34_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_push     (req_push),
  .req_overflow (req_overflow),
  .mem_rd_en    (mem_rd_en),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .tx_data      (tx_data),
  .tx_sop       (tx_sop)
);

// File: tb/cell_tx_aal34_tb_top.sv
`timescale 1ns/1ps
module cell_tx_aal34_tb_top;
  localparam int HAW = 6;
  localparam int MAW = HAW + 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_push = 1'b0;
  logic [HAW-1:0] req_holder = '0;
  logic           req_crc_en = 1'b0;
  logic           req_overflow;
  logic           mem_rd_en;
  logic [MAW-1:0] mem_rd_addr;
  logic [7:0]     mem_rd_data = 8'h00;
  logic           tx_valid;
  logic           tx_ready = 1'b0;
  logic [7:0]     tx_data;
  logic           tx_sop;

  always #2 clk = ~clk;

  cell_tx_aal34 #(.HOLDER_AW(HAW), .FIFO_DEPTH(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_push(req_push), .req_holder(req_holder),
    .req_crc_en(req_crc_en), .req_overflow(req_overflow), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_sop(tx_sop));

  logic [7:0] mem [1 << MAW];
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int rmode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] exp_data[$];
  bit         exp_sop[$];
  string      exp_tag[$];
  bit         exp_cellcrc[$];
  bit   prev_stall = 0;
  logic [7:0] prev_data = 0;
  logic prev_sop = 0;
  int   first_sop = -1;
  int   last_acc = -1;
  int   rx_pos = 0;
  bit   rx_crc_on = 0;
  logic [9:0] rx_crc = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [9:0] step(input logic [9:0] c, input logic b);
    logic [9:0] r;
    r = {c[8:0], 1'b0};
    if (c[9] ^ b) r = r ^ 10'h233;
    return r;
  endfunction

  task automatic expect_cell(input int h, input bit crc);
    logic [9:0] c;
    int base;
    base = h * 64;
    c = '0;
    for (int a = 16; a <= 61; a++)
      for (int b = 7; b >= 0; b--) c = step(c, mem[base + a][b]);
    for (int b = 5; b >= 0; b--) c = step(c, mem[base + 62][b]);
    exp_cellcrc.push_back(crc);
    for (int o = 12; o <= 63; o++) begin
      exp_sop.push_back(o == 12);
      if (crc && o == 62) begin
        exp_data.push_back({mem[base + 62][5:0], c[9:8]}); exp_tag.push_back("R3");
      end else if (crc && o == 63) begin
        exp_data.push_back(c[7:0]); exp_tag.push_back("R3");
      end else if (o >= 62) begin
        exp_data.push_back(mem[base + o]); exp_tag.push_back("R2");
      end else if (o < 16) begin
        exp_data.push_back(mem[base + o]); exp_tag.push_back("R1");
      end else begin
        exp_data.push_back(mem[base + o]); exp_tag.push_back("R5");
      end
    end
  endtask

  task automatic push(input int h, input bit crc, input bit keep);
    @(negedge clk);
    req_push = 1'b1;
    req_holder = HAW'(h);
    req_crc_en = crc;
    if (keep) expect_cell(h, crc);
  endtask

  task automatic idle();
    @(negedge clk);
    req_push = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 5000 && exp_data.size() > 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R6", exp_data.size(), 0, "bytes still owed after drain");
    chk("R6", tx_valid, 0, "stream idle after all cells");
  endtask

  // output monitor: decides ready, compares every accepted byte
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tx_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? lfsr[0] : 1'b0;
      if (prev_stall) begin
        chk("R7", tx_valid, 1, "valid held through stall");
        chk("R7", tx_data, prev_data, "data held through stall");
        chk("R7", tx_sop, prev_sop, "sop held through stall");
      end
      if (tx_valid && tx_ready) begin
        if (exp_data.size() == 0) begin
          checks++; fails++;
          $display("FAIL R6 unrequested byte: actual %0h expected none", tx_data);
        end else begin
          automatic logic [7:0] ed = exp_data.pop_front();
          automatic bit es = exp_sop.pop_front();
          automatic string et = exp_tag.pop_front();
          chk(et, tx_data, ed, "cell byte");
          chk("R1", tx_sop, es, "start marker");
          if (es) begin
            rx_pos = 0; rx_crc = '0;
            rx_crc_on = exp_cellcrc.size() > 0 ? exp_cellcrc.pop_front() : 1'b0;
            if (first_sop < 0) first_sop = cyc;
          end
          if (rx_pos >= 4)
            for (int b = 7; b >= 0; b--) rx_crc = step(rx_crc, tx_data[b]);
          if (rx_pos == 51 && rx_crc_on)
            chk("R4", rx_crc, 0, "receiver remainder over 48 sent bytes");
          rx_pos++;
          last_acc = cyc;
        end
      end
      prev_stall = tx_valid && !tx_ready;
      prev_data = tx_data;
      prev_sop = tx_sop;
      if (cyc > 150000) begin
        checks++; fails++;
        $display("FAIL R6 watchdog: actual %0d cycles expected < 150000", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    for (int a = 0; a < (1 << MAW); a++) mem[a] = 8'((a * 29 + 7) ^ (a >> 6) ^ (a >> 3));
    repeat (3) @(negedge clk);
    chk("R1", tx_valid, 0, "valid low in reset");
    chk("R7", mem_rd_en, 0, "no read in reset");
    chk("R8", req_overflow, 0, "overflow low in reset");
    rst_n = 1'b1;

    // phase 1: back-to-back with ready high (R9, R2, R3)
    rmode = 0;
    first_sop = -1;
    push(1, 1, 1); push(2, 0, 1); push(3, 1, 1); idle();
    drain();
    chk("R9", last_acc - first_sop, 155, "cycles across three cells");

    // phase 2: random back-pressure, mixed flags (R7, R6)
    rmode = 1;
    push(4, 1, 1); push(5, 1, 1); push(6, 0, 1); idle();
    repeat (20) @(negedge clk);
    push(7, 1, 1); push(4, 0, 1); idle();
    drain();

    // phase 3: overflow (R8)
    rmode = 2;
    push(8, 1, 1); idle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) push(9 + i, i % 2, 1);
    idle();
    chk("R8", req_overflow, 0, "accepted push raises no overflow");
    push(20, 1, 0); idle();
    chk("R8", req_overflow, 1, "dropped push flagged");
    @(negedge clk);
    chk("R8", req_overflow, 0, "overflow lasts one cycle");
    rmode = 1;
    drain();

    // phase 4: special contents (R3, R4, R5)
    rmode = 0;
    for (int o = 0; o < 64; o++) begin
      mem[30 * 64 + o] = 8'h00;
      mem[31 * 64 + o] = 8'hFF;
    end
    push(30, 1, 1); push(31, 1, 1); push(31, 0, 1); idle();
    drain();
    chk("R4", {24'h0, mem[30 * 64 + 62]}, 0, "zero holder stays zero in memory");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule